// File: doc/BRIEF.md
# Dual Limit-Compare Interval Timer

Two independent 32-bit up-counters sit behind a small auxiliary register port. Each counter has its own count, control and limit register. A counter advances by one every clock cycle. It can instead be told to pause while the processor core reports that it is halted. When the count matches the limit on a cycle where it advances, the counter returns to zero on that advance and keeps running. If interrupts are enabled, a level interrupt flag for that timer is also raised.

Software uses one timer for periodic or one-shot events: it writes the limit, zeroes the count and enables the interrupt. It then acknowledges each interrupt with a write to the control register. With the limit at all-ones the other timer serves as a wrapping free-running time base. The port has no wait states. A write takes effect at the clock edge where the write strobe is sampled. A read returns, on the following cycle, the register value as it stood at that edge.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both control registers are 0, both limit registers are 0xFFFFFFFF, both counts are 0, both interrupt outputs are low and the read data is 0.
- R2: Timer 0 decodes count at 0x021, control at 0x022 and limit at 0x023. Timer 1 decodes count at 0x100, control at 0x101 and limit at 0x102. A write stores the data at the sampled edge. A read strobe sampled at an edge loads the read data with the register value held just before that edge.
- R3: On each advancing cycle the count rises by one. If the count already equals the limit, it becomes 0 instead.
- R4: With control bit 1 set, the count holds on any cycle where the core-halted input is high. With bit 1 clear, it advances whatever the halted input is.
- R5: Any write to a control register clears that timer's interrupt, whatever the data. Data bits 1:0 become the control value, and bits 31:2 of the control register read as 0.
- R6: When the count equals the limit on an advancing cycle and control bit 0 is set, the interrupt output is high from the next edge on. It stays high until a control write clears it.
- R7: A limit match while control bit 0 is clear leaves the interrupt low.
- R8: A count write overrides the advance in the same cycle and suppresses any limit match in that cycle.
- R9: A read of any address other than the six mapped ones returns 0.
- R10: When a control write and an interrupt-raising match fall in the same cycle, the write wins: the interrupt ends low, and the count still wraps to 0.
- R11: The two timers are independent. Writes, gating and matches of one never change the other's count, control or interrupt.
- R12: With the limit at 0xFFFFFFFF, a count of 0xFFFFFFFF wraps to 0 on the next advance. With interrupts enabled, that wrap raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aux_addr | input | 12 | Register address |
| aux_wdata | input | 32 | Write data |
| aux_wr | input | 1 | Write strobe, one cycle per write |
| aux_rd | input | 1 | Read strobe |
| aux_rdata | output | 32 | Registered read data, valid the cycle after the strobe |
| core_halted | input | 1 | High while the core is halted |
| irq0 | output | 1 | Timer 0 level interrupt |
| irq1 | output | 1 | Timer 1 level interrupt |

## Verification
Every result here lands at a single edge. The edge that samples a write updates the register. The edge that sees a count equal to its limit wraps the count and raises the interrupt. The edge that samples a read strobe loads the read data. The bench drives and samples on falling edges only. It opens and closes the halted input around an exact number of rising edges, so every expected count is the start value plus that number, with the wrap applied by hand. Reads are accounted for with the extra edge that each read task spends, and interrupts are checked on the falling edge right after the edge that should set or clear them.

// File: rtl/itmr_pkg.sv
// Package: shared types for the dual interval timer.
// Assumes: control register is two bits wide; all other bits read zero.
package itmr_pkg;

    // Which register of one timer an address selects.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CNT  = 2'd1,
        SEL_CTL  = 2'd2,
        SEL_LIM  = 2'd3
    } reg_sel_e;

    // Control value: bit 1 = pause while halted, bit 0 = interrupt enable.
    typedef struct packed {
        logic gate;
        logic ie;
    } tctl_t;

    localparam int CTL_W = $bits(tctl_t);

endpackage

// File: rtl/itmr_decode.sv
// Module: itmr_decode
// Maps an auxiliary address to the register of one timer at BASE.
// Assumes: count at BASE, control at BASE+1, limit at BASE+2.
module itmr_decode
    import itmr_pkg::*;
#(
    parameter int              AW   = 12,
    parameter logic [AW-1:0]   BASE = '0
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);

    localparam logic [AW-1:0] A_CNT = BASE;
    localparam logic [AW-1:0] A_CTL = AW'(BASE + 1);
    localparam logic [AW-1:0] A_LIM = AW'(BASE + 2);

    // Compare the address against the three register slots.
    always_comb begin
        if (addr == A_CNT)      sel = SEL_CNT;
        else if (addr == A_CTL) sel = SEL_CTL;
        else if (addr == A_LIM) sel = SEL_LIM;
        else                    sel = SEL_NONE;
    end

endmodule

// File: rtl/itmr_channel.sv
// Module: itmr_channel
// One timer: count, control and limit registers plus the interrupt flag.
// Assumes: wr_en is a single-cycle strobe and sel is already decoded.
// Priority: count write over advance; control write over a raising match.
module itmr_channel
    import itmr_pkg::*;
#(
    parameter int            DW      = 32,
    parameter logic [DW-1:0] LIM_RST = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  reg_sel_e      sel,
    input  logic [DW-1:0] wdata,
    input  logic          core_halted,
    output logic [DW-1:0] cnt_q,
    output logic [DW-1:0] lim_q,
    output tctl_t         ctl_q,
    output logic          irq_q
);

    logic cnt_wr;
    logic ctl_wr;
    logic lim_wr;
    logic advance;
    logic at_limit;
    logic hit;

    // Qualify the write strobe per register and form the advance/match terms.
    always_comb begin
        cnt_wr   = wr_en && (sel == SEL_CNT);
        ctl_wr   = wr_en && (sel == SEL_CTL);
        lim_wr   = wr_en && (sel == SEL_LIM);
        advance  = !(ctl_q.gate && core_halted);
        at_limit = (cnt_q == lim_q);
        hit      = advance && at_limit && !cnt_wr;
    end

    // Counter: software load, else step or wrap to zero at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wdata;
        end else if (advance) begin
            cnt_q <= at_limit ? '0 : cnt_q + DW'(1);
        end
    end

    // Limit register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q <= LIM_RST;
        end else if (lim_wr) begin
            lim_q <= wdata;
        end
    end

    // Control register keeps only its low bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q <= tctl_t'(wdata[CTL_W-1:0]);
        end
    end

    // Sticky interrupt flag: any control write clears it, and wins a tie.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (ctl_wr) begin
            irq_q <= 1'b0;
        end else if (hit && ctl_q.ie) begin
            irq_q <= 1'b1;
        end
    end

endmodule

// File: rtl/itmr_rdmux.sv
// Module: itmr_rdmux
// Registered read-back over all timers; unmapped addresses give zero.
// Assumes: at most one timer decodes any address (selects are OR-ed).
module itmr_rdmux
    import itmr_pkg::*;
#(
    parameter int DW = 32,
    parameter int NT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  reg_sel_e      sel   [NT],
    input  logic [DW-1:0] cnt   [NT],
    input  logic [DW-1:0] lim   [NT],
    input  tctl_t         ctl   [NT],
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] rd_mux;

    // OR together the selected register of every timer.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NT; i++) begin
            case (sel[i])
                SEL_CNT: rd_mux = rd_mux | cnt[i];
                SEL_LIM: rd_mux = rd_mux | lim[i];
                SEL_CTL: rd_mux = rd_mux | {{(DW-CTL_W){1'b0}}, ctl[i]};
                default: rd_mux = rd_mux;
            endcase
        end
    end

    // Capture the read value at the strobe edge and hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/dual_interval_timer.sv
// Module: dual_interval_timer (top)
// Two limit-compare timers behind one auxiliary register port.
// Assumes: strobes are single-cycle and synchronous to clk.
module dual_interval_timer
    import itmr_pkg::*;
#(
    parameter int            DW      = 32,
    parameter int            AW      = 12,
    parameter logic [AW-1:0] T0_BASE = 12'h021,
    parameter logic [AW-1:0] T1_BASE = 12'h100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] aux_addr,
    input  logic [DW-1:0] aux_wdata,
    input  logic          aux_wr,
    input  logic          aux_rd,
    output logic [DW-1:0] aux_rdata,
    input  logic          core_halted,
    output logic          irq0,
    output logic          irq1
);

    localparam int NT = 2;

    reg_sel_e      sel_vec [NT];
    logic [DW-1:0] cnt_vec [NT];
    logic [DW-1:0] lim_vec [NT];
    tctl_t         ctl_vec [NT];
    logic [NT-1:0] irq_vec;

    for (genvar g = 0; g < NT; g++) begin : g_tmr
        localparam logic [AW-1:0] BASE = (g == 0) ? T0_BASE : T1_BASE;

        itmr_decode #(
            .AW   (AW),
            .BASE (BASE)
        ) u_dec (
            .addr (aux_addr),
            .sel  (sel_vec[g])
        );

        itmr_channel #(
            .DW      (DW),
            .LIM_RST ({DW{1'b1}})
        ) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (aux_wr),
            .sel         (sel_vec[g]),
            .wdata       (aux_wdata),
            .core_halted (core_halted),
            .cnt_q       (cnt_vec[g]),
            .lim_q       (lim_vec[g]),
            .ctl_q       (ctl_vec[g]),
            .irq_q       (irq_vec[g])
        );
    end

    itmr_rdmux #(
        .DW (DW),
        .NT (NT)
    ) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd_en (aux_rd),
        .sel   (sel_vec),
        .cnt   (cnt_vec),
        .lim   (lim_vec),
        .ctl   (ctl_vec),
        .rdata (aux_rdata)
    );

    // Drive the per-timer interrupt pins.
    always_comb begin
        irq0 = irq_vec[0];
        irq1 = irq_vec[1];
    end

endmodule

// File: rtl/itmr_checker.sv
// Module: itmr_checker
// Temporal properties of the dual interval timer, bound to the top.
module itmr_checker #(
    parameter int            DW      = 32,
    parameter int            AW      = 12,
    parameter logic [AW-1:0] T0_BASE = 12'h021,
    parameter logic [AW-1:0] T1_BASE = 12'h100
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] aux_addr,
    input logic          aux_wr,
    input logic          aux_rd,
    input logic [DW-1:0] aux_rdata,
    input logic          core_halted,
    input logic          irq0,
    input logic          irq1,
    input logic [DW-1:0] cnt0,
    input logic          gate0
);

    localparam logic [AW-1:0] C0 = T0_BASE;
    localparam logic [AW-1:0] K0 = AW'(T0_BASE + 1);
    localparam logic [AW-1:0] L0 = AW'(T0_BASE + 2);
    localparam logic [AW-1:0] C1 = T1_BASE;
    localparam logic [AW-1:0] K1 = AW'(T1_BASE + 1);
    localparam logic [AW-1:0] L1 = AW'(T1_BASE + 2);

    logic mapped;
    logic ctl0_wr;
    logic ctl1_wr;
    logic cnt0_wr;

    // Address classification seen from the port.
    always_comb begin
        mapped  = (aux_addr == C0) || (aux_addr == K0) || (aux_addr == L0) ||
                  (aux_addr == C1) || (aux_addr == K1) || (aux_addr == L1);
        ctl0_wr = aux_wr && (aux_addr == K0);
        ctl1_wr = aux_wr && (aux_addr == K1);
        cnt0_wr = aux_wr && (aux_addr == C0);
    end

    p_ctl_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl0_wr |=> !irq0);

    p_ctl1_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl1_wr |=> !irq1);

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq0 && !ctl0_wr) |=> irq0);

    p_halt_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gate0 && core_halted && !cnt0_wr) |=> (cnt0 == $past(cnt0)));

    p_step_or_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt0_wr |=> (cnt0 == $past(cnt0) + DW'(1) || cnt0 == '0 || cnt0 == $past(cnt0)));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_rd && !mapped) |=> (aux_rdata == '0));

endmodule

bind dual_interval_timer itmr_checker #(
    .DW      (DW),
    .AW      (AW),
    .T0_BASE (T0_BASE),
    .T1_BASE (T1_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .aux_addr    (aux_addr),
    .aux_wr      (aux_wr),
    .aux_rd      (aux_rd),
    .aux_rdata   (aux_rdata),
    .core_halted (core_halted),
    .irq0        (irq0),
    .irq1        (irq1),
    .cnt0        (cnt_vec[0]),
    .gate0       (ctl_vec[0].gate)
);

// File: tb/dual_interval_timer_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module dual_interval_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] aux_addr = '0;
    logic [31:0] aux_wdata = '0;
    logic        aux_wr = 1'b0;
    logic        aux_rd = 1'b0;
    logic [31:0] aux_rdata;
    logic        core_halted = 1'b1;
    logic        irq0;
    logic        irq1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_CNT0 = 12'h021, A_CTL0 = 12'h022, A_LIM0 = 12'h023;
    localparam logic [11:0] A_CNT1 = 12'h100, A_CTL1 = 12'h101, A_LIM1 = 12'h102;

    always #5 clk = ~clk;

    dual_interval_timer u_dual_interval_timer (
        .clk(clk), .rst_n(rst_n), .aux_addr(aux_addr), .aux_wdata(aux_wdata),
        .aux_wr(aux_wr), .aux_rd(aux_rd), .aux_rdata(aux_rdata),
        .core_halted(core_halted), .irq0(irq0), .irq1(irq1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        aux_addr = a; aux_wdata = d; aux_wr = 1'b1;
        @(negedge clk);
        aux_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(negedge clk);
        aux_addr = a; aux_rd = 1'b1;
        @(negedge clk);
        aux_rd = 1'b0;
        v = aux_rdata;
    endtask

    // Exactly n rising edges with the core running.
    task automatic run(input int n);
        @(negedge clk);
        core_halted = 1'b0;
        repeat (n) @(negedge clk);
        core_halted = 1'b1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 irq0", 32'(irq0), 0);
        chk("R1 irq1", 32'(irq1), 0);
        chk("R1 rdata", aux_rdata, 0);
        rd(A_CTL0, v); chk("R1 ctl0", v, 0);
        rd(A_LIM0, v); chk("R1 lim0", v, 32'hFFFF_FFFF);
        rd(A_CTL1, v); chk("R1 ctl1", v, 0);
        rd(A_LIM1, v); chk("R1 lim1", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(A_CTL0, 32'hFFFF_FFFE);
        rd(A_CTL0, v); chk("R5 ctl0 upper bits zero", v, 32'h2);
        wr(A_CTL1, 32'h0000_0002);
        wr(A_LIM0, 32'h0000_1234);
        rd(A_LIM0, v); chk("R2 lim0", v, 32'h1234);
        wr(A_LIM1, 32'hABCD_0000);
        rd(A_LIM1, v); chk("R2 lim1", v, 32'hABCD_0000);
        wr(A_CNT0, 32'h55);
        rd(A_CNT0, v); chk("R2 cnt0 frozen readback", v, 32'h55);
        wr(A_CNT1, 32'h77);
        rd(A_CNT1, v); chk("R2 cnt1 frozen readback", v, 32'h77);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(A_LIM0, 32'hFFFF_FFFF);
        wr(A_CNT0, 32'd5);
        run(7);
        rd(A_CNT0, v); chk("R3 count advance", v, 32'd12);
    endtask

    task automatic t_gate_off();
        logic [31:0] v;
        wr(A_CTL1, 32'h0);
        wr(A_CNT1, 32'h0);
        repeat (5) @(negedge clk);
        rd(A_CNT1, v); chk("R4 ungated counts while halted", v, 32'd6);
        wr(A_CTL1, 32'h2);
        rd(A_CNT0, v); chk("R11 timer0 untouched", v, 32'd12);
    endtask

    task automatic t_match();
        logic [31:0] v;
        wr(A_LIM0, 32'd3);
        wr(A_CNT0, 32'd0);
        wr(A_CTL0, 32'h3);
        run(3);
        chk("R6 no irq before match", 32'(irq0), 0);
        rd(A_CNT0, v); chk("R3 at limit", v, 32'd3);
        run(1);
        chk("R6 irq on match", 32'(irq0), 1);
        rd(A_CNT0, v); chk("R3 wrap to zero", v, 32'd0);
        run(2);
        chk("R6 irq sticky", 32'(irq0), 1);
        chk("R11 irq1 quiet", 32'(irq1), 0);
        wr(A_CTL0, 32'h3);
        chk("R5 ctl write clears irq", 32'(irq0), 0);
    endtask

    task automatic t_no_ie();
        logic [31:0] v;
        wr(A_CTL0, 32'h2);
        wr(A_CNT0, 32'd0);
        run(4);
        chk("R7 no irq without enable", 32'(irq0), 0);
        rd(A_CNT0, v); chk("R7 count still wrapped", v, 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        wr(A_LIM0, 32'd2);
        wr(A_CNT0, 32'd0);
        wr(A_CTL0, 32'h3);
        run(2);
        @(negedge clk);
        core_halted = 1'b0; aux_addr = A_CTL0; aux_wdata = 32'h3; aux_wr = 1'b1;
        @(negedge clk);
        aux_wr = 1'b0; core_halted = 1'b1;
        chk("R10 write beats match", 32'(irq0), 0);
        rd(A_CNT0, v); chk("R10 count wrapped", v, 32'd0);
        run(3);
        chk("R10 next match raises", 32'(irq0), 1);
        wr(A_CTL0, 32'h3);
    endtask

    task automatic t_cnt_write();
        logic [31:0] v;
        wr(A_CNT0, 32'd2);
        @(negedge clk);
        core_halted = 1'b0; aux_addr = A_CNT0; aux_wdata = 32'd7; aux_wr = 1'b1;
        @(negedge clk);
        aux_wr = 1'b0; core_halted = 1'b1;
        chk("R8 match suppressed", 32'(irq0), 0);
        rd(A_CNT0, v); chk("R8 write beats advance", v, 32'd7);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        wr(A_LIM0, 32'hFFFF_FFFF);
        wr(A_CNT0, 32'hFFFF_FFFE);
        run(1);
        chk("R12 no irq below top", 32'(irq0), 0);
        rd(A_CNT0, v); chk("R12 at top", v, 32'hFFFF_FFFF);
        run(1);
        chk("R12 irq on full wrap", 32'(irq0), 1);
        rd(A_CNT0, v); chk("R12 wrapped to zero", v, 32'd0);
        wr(A_CTL0, 32'h2);
        chk("R5 cleared by write", 32'(irq0), 0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(A_LIM0, v); chk("R2 lim0 before unmapped", v, 32'hFFFF_FFFF);
        rd(12'h024, v); chk("R9 0x024", v, 0);
        rd(A_LIM1, v);
        rd(12'h020, v); chk("R9 0x020", v, 0);
        rd(12'h103, v); chk("R9 0x103", v, 0);
    endtask

    task automatic t_timer1_irq();
        wr(A_LIM1, 32'd1);
        wr(A_CNT1, 32'd0);
        wr(A_CTL1, 32'h3);
        run(2);
        chk("R6 irq1 on match", 32'(irq1), 1);
        chk("R11 irq0 stays low", 32'(irq0), 0);
        wr(A_CTL1, 32'h0);
        chk("R5 irq1 cleared", 32'(irq1), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_count();
        t_gate_off();
        t_match();
        t_no_ie();
        t_collide();
        t_cnt_write();
        t_wrap();
        t_unmapped();
        t_timer1_irq();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule